// File: doc/BRIEF.md
# LLC Rectifier Conduction Stage Classifier

This block follows which secondary rectifier branch of an LLC resonant converter is conducting. It needs no current sensor. Its inputs are a signed sample of the resonant-inductor voltage, a signed sample of the output voltage and the two primary gate drive levels. Every sample that is flagged valid moves the block one step. It reports one of three stages: P (upper branch conducts), N (lower branch conducts) or O (no rectifier current).

The switching period is divided at the falling edges of the two gate drives. Within each half, the block compares the scaled inductor voltage (magnetizing-to-resonant ratio times vLr) against the turns ratio times the output voltage. It also counts upward jumps of the inductor voltage. A jump is a step between consecutive samples that is larger than a programmable threshold.

When a second jump arrives while the leading branch conducts, the block works out the magnetizing voltage as ratio/(ratio+1) times (n·Vo + vLr). That value decides whether conduction passes to the other branch or stops.

The second half is the mirror image of the first. The inductor voltage is negated and the P and N roles swap. A mode input exchanges P and N again for operation above resonance. All constants are unsigned fixed point with FRAC fraction bits. Products saturate to the accumulator range.

Top module: `llc_stage_classifier`

## Requirements
- R1: After reset the stage output is O and both strobes are low. Stage codes: O = 2'b00, P = 2'b01, N = 2'b10. The code 2'b11 never appears.
- R2: A valid sample in which drive_b has fallen, compared with the previous valid sample, starts the first half. A fall of drive_a starts the second half. half_start_o is high for exactly the one cycle after that sample.
- R3: At a half start, the conduction test is applied to the previous valid inductor sample, with the new half's polarity. A pass sets the stage to the leading code; a fail sets it to O.
- R4: In O, before the leading branch has conducted in this half, the stage moves to the leading code on a sample that passes the test. This happens only once a jump has been seen in this half, either on that sample or earlier.
- R5: A jump is a polarity-adjusted difference between consecutive valid samples that is strictly greater than jump_thr. A difference equal to jump_thr is not a jump.
- R6: In the leading code, a jump when an earlier jump has already been seen in this half ends leading conduction. The stage becomes the trailing code if the magnetizing-voltage value exceeds n·Vo, and O otherwise.
- R7: In O after the leading branch has conducted, a sample that passes the test moves the stage to the trailing code.
- R8: The trailing code is held, regardless of jumps or test results, until the next half start.
- R9: In the second half, the inductor sample is negated before testing and jump detection. Below resonance the leading code is N and the trailing code is P; in the first half it is the other way round.
- R10: With above_res high, the leading and trailing codes of each half are exchanged. In the first half the leading code is N.
- R11: The scaled products saturate to the signed accumulator range and never wrap. A full-scale positive inductor sample therefore passes the test.
- R12: Without sample_valid, the stage holds and both strobes are low. stage_chg_o is high for the one cycle after a sample that changed the stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_valid | input | 1 | A new ADC sample pair is present |
| vlr_sample | input | SAMP_W | Signed resonant-inductor voltage sample |
| vout_sample | input | SAMP_W | Signed output voltage sample |
| drive_a | input | 1 | Primary gate level whose fall ends the first half |
| drive_b | input | 1 | Primary gate level whose fall ends the second half |
| above_res | input | 1 | 1 selects operation above resonance |
| lambda_q | input | K_W | Magnetizing-to-resonant inductance ratio, unsigned fixed point |
| turns_q | input | K_W | Transformer turns ratio, unsigned fixed point |
| mag_frac_q | input | K_W | Precomputed ratio/(ratio+1), unsigned fixed point |
| jump_thr | input | SAMP_W | Jump threshold in sample units |
| stage_o | output | 2 | Conduction stage code |
| half_start_o | output | 1 | One-cycle strobe after a half-cycle start |
| stage_chg_o | output | 1 | One-cycle strobe after a stage change |

## Verification
The stage sequence is driven through several input patterns:
- Below resonance, a first half running O, P, N and then its mirrored second half running N, P. This separates the half polarity from the P/N role swap.
- A half where leading conduction ends in O and only later passes to the trailing branch. A further half that starts directly in the leading stage. Together these show the difference between the magnetizing test and the plain test, and between the first and second jump.
- The above-resonance mode, which shows the mode swap acting on top of the half swap.
- A jump equal to the threshold against one a step larger, plus idle cycles with moving inputs.
- A full-scale inductor sample, which only passes the test when the product saturates instead of wrapping.

// File: rtl/llc_stage_pkg.sv
package llc_stage_pkg;
  typedef enum logic [1:0] {
    STG_O = 2'b00,
    STG_P = 2'b01,
    STG_N = 2'b10
  } stage_e;

  // The branch that does not conduct first in a half
  function automatic logic [1:0] other_branch(input logic [1:0] code);
    return (code == STG_P) ? STG_N : STG_P;
  endfunction
endpackage

// File: rtl/llc_gate_edges.sv
module llc_gate_edges #(
  parameter int unsigned NG = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [NG-1:0] lvl,
  output logic [NG-1:0] fall
);
  for (genvar g = 0; g < NG; g++) begin : g_ch
    logic held;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  held <= 1'b0;
      else if (en) held <= lvl[g];
    end
    assign fall[g] = held & ~lvl[g];
  end
endmodule

// File: rtl/llc_jump_det.sv
module llc_jump_det #(
  parameter int unsigned SAMP_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic signed [SAMP_W-1:0] vlr,
  input  logic                     negate,
  input  logic        [SAMP_W-1:0] thr,
  output logic signed [SAMP_W-1:0] prev_o,
  output logic                     jump
);
  localparam int unsigned DW = SAMP_W + 2;

  logic signed [SAMP_W-1:0] prev_q;
  logic signed [DW-1:0]     diff, diff_m;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  prev_q <= '0;
    else if (en) prev_q <= vlr;
  end

  always_comb begin
    diff   = DW'(vlr) - DW'(prev_q);
    diff_m = negate ? -diff : diff;
    jump   = diff_m > $signed({2'b00, thr});
  end

  assign prev_o = prev_q;
endmodule

// File: rtl/llc_stage_fsm.sv
module llc_stage_fsm
  import llc_stage_pkg::*;
#(
  parameter int unsigned SAMP_W = 16,
  parameter int unsigned K_W    = 16,
  parameter int unsigned FRAC   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sample_valid,
  input  logic                     above_res,
  input  logic signed [SAMP_W-1:0] vlr,
  input  logic signed [SAMP_W-1:0] vlr_prev,
  input  logic signed [SAMP_W-1:0] vout,
  input  logic        [K_W-1:0]    lambda_q,
  input  logic        [K_W-1:0]    turns_q,
  input  logic        [K_W-1:0]    mag_q,
  input  logic                     fall_a,
  input  logic                     fall_b,
  input  logic                     jump,
  output logic [1:0]               stage_q,
  output logic                     second_q,
  output logic                     half_start_q,
  output logic                     stage_chg_q,
  output logic [1:0]               lead_code,
  output logic [1:0]               trail_code,
  output logic                     half_edge
);
  localparam int unsigned ACC_W = SAMP_W + 2;
  localparam int unsigned IN_W  = ACC_W + 1;
  localparam int unsigned PW    = IN_W + K_W + 1;
  localparam logic signed [PW-1:0] SAT_HI =
    $signed({{(PW-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}});
  localparam logic signed [PW-1:0] SAT_LO = ~SAT_HI;

  // Signed value times unsigned fixed-point constant, saturated
  function automatic logic signed [ACC_W-1:0] qmul(
    input logic signed [IN_W-1:0] a, input logic [K_W-1:0] k);
    logic signed [PW-1:0] full, sh;
    full = PW'(a) * $signed({{(PW-K_W){1'b0}}, k});
    sh   = full >>> FRAC;
    if (sh > SAT_HI)      return SAT_HI[ACC_W-1:0];
    else if (sh < SAT_LO) return SAT_LO[ACC_W-1:0];
    else                  return sh[ACC_W-1:0];
  endfunction

  function automatic logic signed [IN_W-1:0] mir(
    input logic signed [SAMP_W-1:0] v, input logic neg);
    logic signed [IN_W-1:0] e;
    e = IN_W'(v);
    return neg ? -e : e;
  endfunction

  logic                     lead_done_q, jseen_q;
  logic                     new_second, lead_done_n, jseen_n;
  logic [1:0]               nxt;
  logic signed [ACC_W-1:0]  nvo, mag_v;
  logic signed [IN_W-1:0]   vm_now, vm_prev, sum_v;
  logic                     pass_now, pass_prev, mag_pass, jmp;

  always_comb begin
    half_edge  = sample_valid & (fall_a | fall_b);
    new_second = fall_b ? 1'b0 : (fall_a ? 1'b1 : second_q);
    lead_code  = (~new_second ^ above_res) ? STG_P : STG_N;
    trail_code = other_branch(lead_code);
    vm_now     = mir(vlr, new_second);
    vm_prev    = mir(vlr_prev, new_second);
    nvo        = qmul(IN_W'(vout), turns_q);
    pass_now   = qmul(vm_now, lambda_q) > nvo;
    pass_prev  = qmul(vm_prev, lambda_q) > nvo;
    sum_v      = IN_W'(nvo) + vm_now;
    mag_v      = qmul(sum_v, mag_q);
    mag_pass   = mag_v > nvo;
    jmp        = jump & ~half_edge;

    nxt         = stage_q;
    lead_done_n = lead_done_q;
    jseen_n     = jseen_q | jmp;
    if (half_edge) begin
      nxt         = pass_prev ? lead_code : STG_O;
      lead_done_n = pass_prev;
      jseen_n     = 1'b0;
    end else if (stage_q == STG_O) begin
      if (!lead_done_q) begin
        if ((jseen_q | jmp) && pass_now) begin
          nxt         = lead_code;
          lead_done_n = 1'b1;
        end
      end else if (pass_now) begin
        nxt = trail_code;
      end
    end else if (stage_q == lead_code) begin
      if (jmp && jseen_q) nxt = mag_pass ? trail_code : STG_O;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q      <= STG_O;
      second_q     <= 1'b0;
      lead_done_q  <= 1'b0;
      jseen_q      <= 1'b0;
      half_start_q <= 1'b0;
      stage_chg_q  <= 1'b0;
    end else begin
      half_start_q <= half_edge;
      stage_chg_q  <= sample_valid && (nxt != stage_q);
      if (sample_valid) begin
        stage_q     <= nxt;
        second_q    <= new_second;
        lead_done_q <= lead_done_n;
        jseen_q     <= jseen_n;
      end
    end
  end
endmodule

// File: rtl/llc_stage_classifier.sv
module llc_stage_classifier #(
  parameter int unsigned SAMP_W = 16,
  parameter int unsigned K_W    = 16,
  parameter int unsigned FRAC   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sample_valid,
  input  logic signed [SAMP_W-1:0] vlr_sample,
  input  logic signed [SAMP_W-1:0] vout_sample,
  input  logic                     drive_a,
  input  logic                     drive_b,
  input  logic                     above_res,
  input  logic        [K_W-1:0]    lambda_q,
  input  logic        [K_W-1:0]    turns_q,
  input  logic        [K_W-1:0]    mag_frac_q,
  input  logic        [SAMP_W-1:0] jump_thr,
  output logic [1:0]               stage_o,
  output logic                     half_start_o,
  output logic                     stage_chg_o
);
  logic [1:0]               falls;
  logic signed [SAMP_W-1:0] vlr_prev;
  logic                     jump_raw, second_half, half_edge, jump_evt;
  logic [1:0]               lead_code, trail_code;

  llc_gate_edges #(.NG(2)) u_edges (
    .clk(clk), .rst_n(rst_n), .en(sample_valid),
    .lvl({drive_b, drive_a}), .fall(falls)
  );

  llc_jump_det #(.SAMP_W(SAMP_W)) u_jump (
    .clk(clk), .rst_n(rst_n), .en(sample_valid), .vlr(vlr_sample),
    .negate(second_half), .thr(jump_thr), .prev_o(vlr_prev), .jump(jump_raw)
  );

  llc_stage_fsm #(.SAMP_W(SAMP_W), .K_W(K_W), .FRAC(FRAC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .above_res(above_res),
    .vlr(vlr_sample), .vlr_prev(vlr_prev), .vout(vout_sample),
    .lambda_q(lambda_q), .turns_q(turns_q), .mag_q(mag_frac_q),
    .fall_a(falls[0]), .fall_b(falls[1]), .jump(jump_raw),
    .stage_q(stage_o), .second_q(second_half), .half_start_q(half_start_o),
    .stage_chg_q(stage_chg_o), .lead_code(lead_code), .trail_code(trail_code),
    .half_edge(half_edge)
  );

  // Event wire brought out for the checker
  assign jump_evt = sample_valid & jump_raw & ~half_edge;
endmodule

// File: rtl/llc_stage_chk.sv
module llc_stage_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sample_valid,
  input logic [1:0] stage_o,
  input logic       half_start_o,
  input logic       stage_chg_o,
  input logic       half_edge,
  input logic       jump_evt,
  input logic [1:0] lead_code,
  input logic [1:0] trail_code
);
  p_stage_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stage_o != 2'b11);

  p_half_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && half_edge) |=> half_start_o);

  p_lead_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && !half_edge && stage_o == lead_code && !jump_evt) |=> $stable(stage_o));

  p_trail_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && !half_edge && stage_o == trail_code) |=> $stable(stage_o));

  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |=> ($stable(stage_o) && !half_start_o && !stage_chg_o));

  p_chg_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
    stage_chg_o |-> (stage_o != $past(stage_o)));
endmodule

bind llc_stage_classifier llc_stage_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .stage_o(stage_o),
  .half_start_o(half_start_o), .stage_chg_o(stage_chg_o), .half_edge(half_edge),
  .jump_evt(jump_evt), .lead_code(lead_code), .trail_code(trail_code)
);

// File: tb/tb_llc_stage_classifier.sv
module tb_llc_stage_classifier;
  localparam logic [1:0] SO = 2'b00, SP = 2'b01, SN = 2'b10;

  logic clk = 1'b0, rst_n = 1'b0, sample_valid = 1'b0;
  logic signed [15:0] vlr = '0, vout = 16'sd100;
  logic drive_a = 1'b0, drive_b = 1'b0, above_res = 1'b0;
  logic [15:0] lambda_q = 16'd1280;  // 5.0 in Q8
  logic [15:0] turns_q  = 16'd512;   // 2.0 in Q8
  logic [15:0] mag_q    = 16'd213;   // about 5/6 in Q8
  logic [15:0] thr      = 16'd50;
  logic [1:0]  stage;
  logic        hs, chg;
  int checks = 0, errors = 0;
  logic [1:0] last_exp = 2'b00;
  bit done = 0;

  always #5 clk = ~clk;

  llc_stage_classifier dut (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .vlr_sample(vlr),
    .vout_sample(vout), .drive_a(drive_a), .drive_b(drive_b), .above_res(above_res),
    .lambda_q(lambda_q), .turns_q(turns_q), .mag_frac_q(mag_q), .jump_thr(thr),
    .stage_o(stage), .half_start_o(hs), .stage_chg_o(chg)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Conduction test with the bench constants: 5*v > 2*Vo
  function automatic bit cond(input int v);
    return 5 * v > 2 * 100;
  endfunction

  // One valid sample; stage and strobes checked on the following negedge
  task automatic smp(input bit a, input bit b, input int v,
                     input logic [1:0] exp, input bit exp_hs, input string tag);
    drive_a = a; drive_b = b; vlr = 16'(v); sample_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sample_valid = 1'b0;
    chk(stage == exp, {tag, " stage"}, int'(stage), int'(exp));
    chk(hs == exp_hs, {tag, " half_start"}, int'(hs), int'(exp_hs));
    chk(chg == (exp != last_exp), {tag, " stage_chg"}, int'(chg), int'(exp != last_exp));
    last_exp = exp;
  endtask

  task automatic t_reset;
    chk(stage == SO, "R1 reset stage", int'(stage), 0);
    chk(!hs && !chg, "R1 reset strobes", int'({hs, chg}), 0);
  endtask

  task automatic t_first_below;
    smp(0, 1, 0,   SO, 0, "R2 pre");
    smp(0, 0, 0,   SO, 1, "R2 drive_b fall");
    smp(1, 0, 100, SP, 0, "R4 jump then pass");
    smp(1, 0, 120, SP, 0, "R4 hold");
    smp(1, 0, 200, SN, 0, "R6 exit to trail");
    smp(1, 0, 10,  SN, 0, "R8 hold low");
    smp(1, 0, 300, SN, 0, "R8 hold on jump");
  endtask

  task automatic t_second_below;
    smp(0, 0, 10,   SO, 1, "R2 drive_a fall");
    smp(0, 1, -100, SN, 0, "R9 mirrored lead N");
    smp(0, 1, -200, SP, 0, "R9 mirrored trail P");
  endtask

  task automatic t_exit_to_o;
    smp(0, 0, -200, SO, 1, "R3 start fail");
    smp(1, 0, 100,  SP, 0, "R4 lead");
    smp(1, 0, -40,  SP, 0, "R6 no jump");
    chk(!cond(30) && (((200 + 30) * 213) >>> 8) <= 200, "R6 model", 0, 0);
    smp(1, 0, 30,   SO, 0, "R6 exit to O");
    smp(1, 0, 20,   SO, 0, "R7 stay O");
    smp(1, 0, 60,   SN, 0, "R7 O to trail");
    smp(1, 0, -80,  SN, 0, "R8 hold");
  endtask

  task automatic t_start_in_lead;
    smp(0, 0, -80,  SN, 1, "R3 start pass");
    smp(0, 1, -180, SN, 0, "R6 first jump no exit");
    smp(0, 1, -260, SP, 0, "R6 second jump exit");
  endtask

  task automatic t_above;
    above_res = 1'b1;
    smp(0, 0, -260, SO, 1, "R10 start");
    smp(1, 0, 100,  SN, 0, "R10 lead N");
    smp(1, 0, 200,  SP, 0, "R10 trail P");
  endtask

  task automatic t_threshold;
    smp(0, 0, 200,  SO, 1, "R5 start");
    smp(0, 1, -100, SP, 0, "R10 second half lead P");
    smp(0, 1, -150, SP, 0, "R5 equal to threshold");
    smp(0, 1, -201, SN, 0, "R5 one above threshold");
  endtask

  task automatic t_idle;
    drive_a = 0; drive_b = 0; vlr = 16'sd5000;
    repeat (3) @(negedge clk);
    chk(stage == SN, "R12 idle stage", int'(stage), int'(SN));
    chk(!hs && !chg, "R12 idle strobes", int'({hs, chg}), 0);
  endtask

  task automatic t_saturate;
    above_res = 1'b0;
    smp(0, 0, -201,  SO, 1, "R11 start");
    smp(1, 0, 32767, SP, 0, "R11 saturated pass");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_below();
    t_second_below();
    t_exit_to_o();
    t_start_in_lead();
    t_above();
    t_threshold();
    t_idle();
    t_saturate();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule